// File: doc/BRIEF.md
# Multiplexed Burst Bus Controller

This block is the processor-side state machine for a 32-bit bus on which address and data share the same wires. An internal core port hands it one request at a time. Each request carries a word-aligned start address, a byte-enable mask, a direction, a lock flag and a burst of one to four words. The controller runs one address state. It then runs data states, and each of these repeats until the ready input is seen low. The access closes with one recovery state. Address bits 3:2 also appear on two dedicated pins, and they step once per word during the burst.

The port width is chosen per request: 8, 16 or 32 bits. On a narrow port each word is split into consecutive transfers. On such a port the byte-enable pins carry the low address bits, and read data is rebuilt in little-endian lane order. An external master can take the bus with a hold request. The controller grants it only from idle or from a recovery state, and it floats every output while the bus is granted away. If the lock pin reads low when reset is released, the block enters a test mode in which nothing is driven until the next reset.

Top module: `mux_bus_ctl`

## Requirements
- R1: Reset (rst_n) is active low. While it is low, and in the cycle it is released, ctl_oe_o, ad_oe_o and holda_o are 0. At the first clock with rst_n high, lock_pin_i is sampled. If it is 1, the block goes idle: ctl_oe_o=1 and ads_n_o, wr_n_o, blast_n_o, lock_n_o are 1. If it is 0, the block enters test mode: ctl_oe_o=0 and ad_oe_o=0 until the next reset, and req_ready_o=0.
- R2: req_ready_o is 1 in idle or in recovery when hold_i is 0. On the clock that accepts a request, the next cycle is the single address state. In that state ads_n_o=0, ad_oe_o=1, ad_o={addr[31:2],2'b00} and wr_n_o=~write. A data state always follows it.
- R3: Each data state repeats while rdy_n_i is 1. A transfer completes on the clock at which rdy_n_i is 0.
- R4: a32_o equals (addr[3:2] + word index) mod 4. It is held steady through wait states.
- R5: width_i encoding: 0 selects 8 bits, 1 selects 16 bits, 2 or 3 selects 32 bits. On a 32-bit port each word is one transfer, with be_n_o=~be and the full word on ad_o or ad_i.
- R6: On a 16-bit port each word is two transfers, s=0 then s=1, with half s on lanes [15:0]. be_n_o is built from bit 3 down to bit 0: bit 3 = ~be[2s+1], bit 2 = 1, bit 1 = s (address bit 1), bit 0 = ~be[2s].
- R7: On an 8-bit port each word is four transfers, s=0..3, with byte s on lanes [7:0]. be_n_o = {2'b11, s}, which puts address bits 1:0 on be_n_o[1:0].
- R8: For reads, rvalid_o pulses for one cycle, in the cycle after the last transfer of each word. At that point rdata_o holds the word, with the transfer s data in byte (or half) position s.
- R9: blast_n_o is 0 only during data states of the final transfer of the burst.
- R10: Exactly one recovery state follows the last data state. The hold state is never entered directly from a data state.
- R11: The hold state is entered from idle or recovery when hold_i is 1. In that state ctl_oe_o=0 and ad_oe_o=0. holda_o rises one clock after entry. When hold_i is seen 0, holda_o falls at that clock and the block goes idle, after which a pending request is accepted.
- R12: lock_n_o is 0 from the address state through recovery for a request with the lock flag, and 1 otherwise. It is driven regardless of the level on lock_pin_i outside reset.
- R13: For writes, wdata_take_o is 1 in the cycle whose clock completes a word's last transfer. In data states ad_oe_o=1 and the lane carries the addressed part of req_wdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| width_i | input | 2 | Port width for the next request |
| req_valid_i | input | 1 | Core request present |
| req_ready_o | output | 1 | Request accepted at this clock |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_lock_i | input | 1 | Request runs with lock asserted |
| req_addr_i | input | 30 | Word address, bits 31:2 |
| req_be_i | input | 4 | Byte-enable mask, active high |
| req_len_i | input | 2 | Burst words minus one |
| req_wdata_i | input | 32 | Write word currently offered |
| wdata_take_o | output | 1 | Current write word consumed |
| rdata_o | output | 32 | Assembled read word |
| rvalid_o | output | 1 | rdata_o valid pulse |
| ad_o | output | 32 | Address/data bus drive value |
| ad_i | input | 32 | Address/data bus sampled value |
| ad_oe_o | output | 1 | Address/data bus driver enable |
| ctl_oe_o | output | 1 | Control pin driver enable |
| ads_n_o | output | 1 | Address state strobe, active low |
| wr_n_o | output | 1 | Direction, low for write |
| be_n_o | output | 4 | Byte enables / low address bits |
| a32_o | output | 2 | Non-multiplexed address bits 3:2 |
| blast_n_o | output | 1 | Final transfer, active low |
| rdy_n_i | input | 1 | Transfer ready, active low |
| lock_n_o | output | 1 | Lock output, active low |
| lock_pin_i | input | 1 | Lock pin level, sampled at reset release |
| hold_i | input | 1 | External bus request |
| holda_o | output | 1 | Bus granted away |

## Verification
Some rules hold on every cycle, and the assertions check those. A data state is never followed by hold. Every address state leads straight into a data state. The word address pins stay still through wait states. The drivers are off whenever hold is acknowledged. Test mode, once entered, is never left. A last transfer accepted with the final-burst flag always leads to recovery. Other behaviour shows up only in the bench's scenarios. These are the lane and byte-enable patterns for each width, the little-endian assembly of read words, the pacing of write data, the release of a pending request after hold, and the reset-time choice between idle and test mode.

// File: rtl/mux_bus_ctl.sv
module mux_bus_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  width_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic        req_lock_i,
  input  logic [31:2] req_addr_i,
  input  logic [3:0]  req_be_i,
  input  logic [1:0]  req_len_i,
  input  logic [31:0] req_wdata_i,
  output logic        wdata_take_o,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic [31:0] ad_o,
  input  logic [31:0] ad_i,
  output logic        ad_oe_o,
  output logic        ctl_oe_o,
  output logic        ads_n_o,
  output logic        wr_n_o,
  output logic [3:0]  be_n_o,
  output logic [1:0]  a32_o,
  output logic        blast_n_o,
  input  logic        rdy_n_i,
  output logic        lock_n_o,
  input  logic        lock_pin_i,
  input  logic        hold_i,
  output logic        holda_o
);
  typedef enum logic [2:0] {S_RST, S_IDLE, S_TA, S_TD, S_TR, S_TH, S_TEST} st_t;
  localparam logic [1:0] W8 = 2'd0, W16 = 2'd1;

  st_t         st;
  logic [31:2] addr_q;
  logic [3:0]  be_q;
  logic [1:0]  len_q, wid_q, word_q, sub_q;
  logic        wr_q, lk_q, holda_q, rvalid_q;
  logic [31:0] rbuf_q, rdata_q, rmerge, wlane;
  logic [3:0]  be_calc;

  wire start_ok  = (st == S_IDLE || st == S_TR) && !hold_i;
  wire accept    = start_ok && req_valid_i;
  wire beat      = (st == S_TD) && !rdy_n_i;
  wire sub_last  = (wid_q == W8) ? (sub_q == 2'd3) : (wid_q == W16) ? sub_q[0] : 1'b1;
  wire word_done = beat && sub_last;
  wire active    = (st == S_TA) || (st == S_TD) || (st == S_TR);

  always_comb begin
    rmerge = rbuf_q;
    wlane  = req_wdata_i;
    be_calc = ~be_q;
    case (wid_q)
      W8: begin
        rmerge[{sub_q, 3'b000} +: 8] = ad_i[7:0];
        wlane   = {24'h0, req_wdata_i[{sub_q, 3'b000} +: 8]};
        be_calc = {2'b11, sub_q};
      end
      W16: begin
        rmerge[{sub_q[0], 4'b0000} +: 16] = ad_i[15:0];
        wlane   = {16'h0, req_wdata_i[{sub_q[0], 4'b0000} +: 16]};
        be_calc = {~be_q[{sub_q[0], 1'b1}], 1'b1, sub_q[0], ~be_q[{sub_q[0], 1'b0}]};
      end
      default: rmerge = ad_i;
    endcase
  end

  assign req_ready_o  = start_ok;
  assign wdata_take_o = word_done && wr_q;
  assign rdata_o      = rdata_q;
  assign rvalid_o     = rvalid_q;
  assign holda_o      = holda_q;
  assign ad_o         = (st == S_TA) ? {addr_q, 2'b00} : wlane;
  assign ad_oe_o      = (st == S_TA) || (st == S_TD && wr_q);
  assign ctl_oe_o     = active || (st == S_IDLE);
  assign ads_n_o      = !(st == S_TA);
  assign wr_n_o       = !(active && wr_q);
  assign lock_n_o     = !(active && lk_q);
  assign blast_n_o    = !((st == S_TD) && (word_q == len_q) && sub_last);
  assign be_n_o       = active ? be_calc : 4'hF;
  assign a32_o        = addr_q[3:2] + word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RST;
      addr_q <= '0; be_q <= '0; len_q <= '0; wid_q <= '0;
      word_q <= '0; sub_q <= '0; wr_q <= 1'b0; lk_q <= 1'b0;
      holda_q <= 1'b0; rvalid_q <= 1'b0; rbuf_q <= '0; rdata_q <= '0;
    end else begin
      rvalid_q <= word_done && !wr_q;
      holda_q  <= (st == S_TH) && hold_i;
      if (beat) rbuf_q <= rmerge;
      if (word_done && !wr_q) rdata_q <= rmerge;
      if (accept) begin
        addr_q <= req_addr_i; be_q <= req_be_i; len_q <= req_len_i;
        wid_q <= width_i; wr_q <= req_write_i; lk_q <= req_lock_i;
        word_q <= '0; sub_q <= '0;
      end
      case (st)
        S_RST:  st <= lock_pin_i ? S_IDLE : S_TEST;
        S_IDLE: if (hold_i) st <= S_TH; else if (req_valid_i) st <= S_TA;
        S_TA:   st <= S_TD;
        S_TD: if (beat) begin
          if (sub_last) begin
            sub_q <= '0;
            if (word_q == len_q) st <= S_TR;
            else word_q <= word_q + 2'd1;
          end else sub_q <= sub_q + 2'd1;
        end
        S_TR: if (hold_i) st <= S_TH; else if (req_valid_i) st <= S_TA; else st <= S_IDLE;
        S_TH:   if (!hold_i) st <= S_IDLE;
        S_TEST: st <= S_TEST;
        default: st <= S_RST;
      endcase
    end
  end
endmodule

module mux_bus_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       ads_n,
  input logic       rdy_n,
  input logic [1:0] a32,
  input logic       holda,
  input logic       ctl_oe,
  input logic       ad_oe,
  input logic       blast_n
);
  // R10
  no_td_to_th_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |=> (st != 3'd5));
  // R11
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holda |-> (!ctl_oe && !ad_oe));
  // R11
  holda_after_th_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holda) |-> ($past(st) == 3'd5));
  // R2
  single_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> (ads_n && st == 3'd3));
  // R4
  a32_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && rdy_n) |=> $stable(a32));
  // R1
  test_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6) |=> (st == 3'd6 && !ctl_oe && !ad_oe));
  // R9
  blast_to_tr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && !blast_n && !rdy_n) |=> (st == 3'd4));
endmodule

bind mux_bus_ctl mux_bus_ctl_chk chk (
  .clk(clk), .rst_n(rst_n), .st(st), .ads_n(ads_n_o), .rdy_n(rdy_n_i),
  .a32(a32_o), .holda(holda_o), .ctl_oe(ctl_oe_o), .ad_oe(ad_oe_o),
  .blast_n(blast_n_o)
);

// File: tb/mux_bus_ctl_test.sv
module mux_bus_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [1:0]  V_W   [NV] = '{2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd0, 2'd3, 2'd1};
  localparam logic        V_WR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic        V_LK  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [1:0]  V_LEN [NV] = '{2'd0, 2'd3, 2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2'd2};
  localparam logic [3:0]  V_BE  [NV] = '{4'hF, 4'hF, 4'hF, 4'h6, 4'hF, 4'hF, 4'h9, 4'hC};
  localparam logic [31:0] V_AD  [NV] = '{32'h1000, 32'h2008, 32'h3004, 32'h400C,
                                         32'h5000, 32'h600C, 32'h7004, 32'h800C};
  localparam int          V_WT  [NV] = '{0, 1, 0, 2, 1, 0, 0, 1};

  logic clk = 0, rst_n = 0;
  logic [1:0] width_i = 2'd2;
  logic req_valid_i = 0, req_write_i = 0, req_lock_i = 0;
  logic [31:2] req_addr_i = '0;
  logic [3:0] req_be_i = 4'hF;
  logic [1:0] req_len_i = '0;
  logic [31:0] req_wdata_i = '0, ad_i = '0;
  logic rdy_n_i = 1, lock_pin_i = 1, hold_i = 0;
  logic req_ready_o, wdata_take_o, rvalid_o, ad_oe_o, ctl_oe_o, ads_n_o, wr_n_o;
  logic blast_n_o, lock_n_o, holda_o;
  logic [31:0] rdata_o, ad_o;
  logic [3:0] be_n_o;
  logic [1:0] a32_o;
  int n_chk = 0, n_fail = 0;

  mux_bus_ctl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rpat(logic [31:0] a);
    return {a[15:0] ^ 16'h5AC3, ~a[15:0]};
  endfunction
  function automatic logic [31:0] wpat(int i, int w);
    return {8'(i) ^ 8'hD1, 8'(w) ^ 8'h62, 8'hB3, 8'(i + w + 4)};
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic run_txn(int i);
    int nsub = (V_W[i] == 2'd0) ? 4 : (V_W[i] == 2'd1) ? 2 : 1;
    logic wr = V_WR[i];
    width_i = V_W[i]; req_write_i = wr; req_lock_i = V_LK[i];
    req_addr_i = V_AD[i][31:2]; req_be_i = V_BE[i]; req_len_i = V_LEN[i];
    req_wdata_i = wpat(i, 0); req_valid_i = 1; rdy_n_i = 1;
    #1;
    chk(req_ready_o == 1, "R2 ready", 32'(req_ready_o), 1);
    @(negedge clk); req_valid_i = 0; #1;
    chk(!ads_n_o && ad_oe_o && ctl_oe_o, "R2 addr state", {ads_n_o, ad_oe_o, ctl_oe_o}, 3'b011);
    chk(ad_o == {V_AD[i][31:2], 2'b00}, "R2 address", ad_o, {V_AD[i][31:2], 2'b00});
    chk(wr_n_o == !wr, "R2 direction", 32'(wr_n_o), 32'(!wr));
    chk(lock_n_o == !V_LK[i], "R12 lock in Ta", 32'(lock_n_o), 32'(!V_LK[i]));
    @(negedge clk);
    for (int w = 0; w <= int'(V_LEN[i]); w++) begin
      logic [31:0] wa = {V_AD[i][31:4], V_AD[i][3:2] + 2'(w), 2'b00};
      req_wdata_i = wpat(i, w);
      for (int s = 0; s < nsub; s++) begin
        int wt = V_WT[i];
        logic [3:0] ebe;
        logic [31:0] wd = wpat(i, w);
        logic blast_exp = !(w == int'(V_LEN[i]) && s == nsub - 1);
        if (nsub == 1) ebe = ~V_BE[i];
        else if (nsub == 2) ebe = {~V_BE[i][2*s+1], 1'b1, 1'(s), ~V_BE[i][2*s]};
        else ebe = {2'b11, 2'(s)};
        while (1) begin
          rdy_n_i = (wt != 0);
          if (!wr) begin
            if (nsub == 4) ad_i = {24'hE1E2E3, rpat(wa)[8*s +: 8]};
            else if (nsub == 2) ad_i = {16'hE4E5, rpat(wa)[16*s +: 16]};
            else ad_i = rpat(wa);
          end
          #1;
          chk(a32_o == 2'(V_AD[i][3:2] + 2'(w)), "R4 a32", 32'(a32_o), 32'(V_AD[i][3:2] + 2'(w)));
          chk(ads_n_o == 1, "R3 data state", 32'(ads_n_o), 1);
          if (nsub == 1) chk(be_n_o == ebe, "R5 be32", 32'(be_n_o), 32'(ebe));
          else if (nsub == 2) chk(be_n_o == ebe, "R6 be16", 32'(be_n_o), 32'(ebe));
          else chk(be_n_o == ebe, "R7 be8", 32'(be_n_o), 32'(ebe));
          chk(blast_n_o == blast_exp, "R9 blast", 32'(blast_n_o), 32'(blast_exp));
          chk(lock_n_o == !V_LK[i], "R12 lock in Td", 32'(lock_n_o), 32'(!V_LK[i]));
          if (wr) begin
            chk(ad_oe_o == 1, "R13 drive", 32'(ad_oe_o), 1);
            if (nsub == 4) chk(ad_o[7:0] == wd[8*s +: 8], "R13 lane8", 32'(ad_o[7:0]), 32'(wd[8*s +: 8]));
            else if (nsub == 2) chk(ad_o[15:0] == wd[16*s +: 16], "R13 lane16", 32'(ad_o[15:0]), 32'(wd[16*s +: 16]));
            else chk(ad_o == wd, "R13 lane32", ad_o, wd);
          end
          if (wt == 0) begin
            logic te = wr && (s == nsub - 1);
            chk(wdata_take_o == te, "R13 take", 32'(wdata_take_o), 32'(te));
            break;
          end
          chk(wdata_take_o == 0, "R3 wait holds", 32'(wdata_take_o), 0);
          wt--;
          @(negedge clk);
        end
        @(negedge clk);
        if (!wr && s == nsub - 1) begin
          #1;
          chk(rvalid_o == 1, "R8 rvalid", 32'(rvalid_o), 1);
          chk(rdata_o == rpat(wa), "R8 rdata", rdata_o, rpat(wa));
        end
      end
    end
    rdy_n_i = 1; #1;
    chk(ctl_oe_o && ads_n_o && blast_n_o, "R10 recovery", {ctl_oe_o, ads_n_o, blast_n_o}, 3'b111);
    chk(lock_n_o == !V_LK[i], "R12 lock in Tr", 32'(lock_n_o), 32'(!V_LK[i]));
    @(negedge clk); #1;
    chk(lock_n_o && wr_n_o && !rvalid_o, "R10 idle after Tr", {lock_n_o, wr_n_o, rvalid_o}, 3'b110);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    chk(!ctl_oe_o && !ad_oe_o && !holda_o, "R1 in reset", {ctl_oe_o, ad_oe_o, holda_o}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(ctl_oe_o && ads_n_o && wr_n_o && blast_n_o && lock_n_o, "R1 idle",
        {ctl_oe_o, ads_n_o, wr_n_o, blast_n_o, lock_n_o}, 5'b11111);
    lock_pin_i = 0;
    for (int i = 0; i < NV; i++) run_txn(i);
    #1;
    chk(ctl_oe_o == 1, "R12 pin low ignored", 32'(ctl_oe_o), 1);

    // R10 R11: hold raised during a data state
    width_i = 2'd2; req_write_i = 0; req_lock_i = 0; req_addr_i = 30'h0000_0A40;
    req_be_i = 4'hF; req_len_i = 0; req_valid_i = 1;
    @(negedge clk); req_valid_i = 0; hold_i = 1;
    @(negedge clk); rdy_n_i = 0; ad_i = 32'h1234_5678;
    @(negedge clk); rdy_n_i = 1; #1;
    chk(ctl_oe_o && ads_n_o && !holda_o, "R10 Tr before hold", {ctl_oe_o, ads_n_o, holda_o}, 3'b110);
    chk(rdata_o == 32'h1234_5678, "R8 rdata hold case", rdata_o, 32'h1234_5678);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 1; req_addr_i = 30'h0000_0B00; req_wdata_i = 32'hCAFE_0001; #1;
    chk(!ctl_oe_o && !ad_oe_o && !holda_o, "R11 Th floats", {ctl_oe_o, ad_oe_o, holda_o}, 0);
    chk(req_ready_o == 0, "R11 no accept in hold", 32'(req_ready_o), 0);
    @(negedge clk); #1;
    chk(holda_o && !ctl_oe_o, "R11 holda up", {holda_o, ctl_oe_o}, 2'b10);
    hold_i = 0;
    @(negedge clk); #1;
    chk(!holda_o && ctl_oe_o && req_ready_o, "R11 release", {holda_o, ctl_oe_o, req_ready_o}, 3'b011);
    @(negedge clk); req_valid_i = 0; #1;
    chk(ads_n_o == 0, "R11 pending served", 32'(ads_n_o), 0);
    rdy_n_i = 0;
    repeat (3) @(negedge clk);
    rdy_n_i = 1;

    // R1: test mode entry
    rst_n = 0; lock_pin_i = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk); req_valid_i = 1; #1;
    chk(!ctl_oe_o && !ad_oe_o, "R1 test mode", {ctl_oe_o, ad_oe_o}, 0);
    chk(req_ready_o == 0, "R1 test no accept", 32'(req_ready_o), 0);
    lock_pin_i = 1;
    repeat (3) @(negedge clk); #1;
    chk(!ctl_oe_o && !ad_oe_o, "R1 test sticky", {ctl_oe_o, ad_oe_o}, 0);
    req_valid_i = 0;
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk(ctl_oe_o && ads_n_o, "R1 idle after reset", {ctl_oe_o, ads_n_o}, 2'b11);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule